// File: doc/BRIEF.md
# Triggered Multiplexed-Readout Sequencer

This block drives the readout of an analogue front-end chip whose channels each end in a sample-and-hold stage. All channels share one multiplexed analogue output. A trigger from a separate fast-trigger chip starts an event. The block waits a programmed shaping-peak delay and then raises a hold line, which freezes every channel at once. Next it pushes a single token bit into the chip's multiplexer shift register and toggles a readout clock, so that the channels reach the output one after another.

The multiplexed output is converted by an external 12-bit ADC. The ADC is clocked by the falling edge of the readout clock and has a programmable pipeline latency, counted in readout clocks. The block adds that many readout periods to the event and discards the stale samples at the front. Each word it keeps is tagged with its channel index and with start and end flags. Words leave through a one-entry valid/ready register. Backpressure at that register freezes the readout clock.

When the last word has been captured, the block drops hold and token and pulses a reset line to the chip. It returns to idle once the last word has been accepted. Triggers that arrive while an event is in progress are ignored.

Top module: `mux_readout_seq`

## Requirements
- R1: The asynchronous trigger passes through a two-flop synchroniser. Only a rising edge seen while idle starts an event. `busy_o` stays high from the start of the event until the chip reset has finished and the last word has been accepted. A trigger held high does not start a second event.
- R2: `hold_o` rises exactly P clock cycles after `busy_o` rises. P is `peak_dly_i`, and a value of 0 selects the default `PEAK_DFLT` of 200 cycles.
- R3: `token_o` goes high together with `hold_o`, before the first readout-clock rising edge. It is low from the first falling edge on. `hold_o` is high at every readout-clock rising edge, and `token_o` is never high without `hold_o`.
- R4: Each high phase of `rclk_o` lasts exactly `rclk_hi_i` cycles, and each low phase lasts at least `rclk_lo_i` cycles (0 counts as 1). An event has exactly N_CH + `adc_lat_i` rising edges.
- R5: Word i of an event (i = 0..N_CH-1) carries channel index i in bits 16:12 and that channel's amplitude in bits 11:0. Channel 0 is the first channel the token selects. The amplitude is the ADC output captured after the ADC's latency of `adc_lat_i` readout clocks.
- R6: Bit 18 (start of event) is set only on word 0, and bit 17 (end of event) only on word N_CH-1.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the word stays valid and unchanged. The readout clock does not rise while it is low in that state.
- R8: Triggers that arrive during the peak wait or the readout have no effect. An event yields exactly N_CH words and one hold pulse.
- R9: After the last capture, `hold_o` falls and `chip_rst_o` is high for exactly `RST_CYC` cycles. `hold_o` stays low during that pulse.
- R10: While `rst_ni` is low, including in the middle of an event, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous event trigger |
| peak_dly_i | input | CNT_W | Cycles from event start to hold; 0 selects the default |
| rclk_hi_i | input | TW | Readout clock high time in cycles |
| rclk_lo_i | input | TW | Readout clock minimum low time in cycles |
| adc_lat_i | input | LAT_W | ADC pipeline latency in readout clocks |
| adc_data_i | input | ADC_W | ADC output word |
| out_ready_i | input | 1 | Downstream ready |
| hold_o | output | 1 | Sample-and-hold control to the chip |
| token_o | output | 1 | Token bit into the chip's multiplexer register |
| rclk_o | output | 1 | Readout clock to the chip |
| chip_rst_o | output | 1 | Reset pulse to the chip's readout logic |
| busy_o | output | 1 | Event in progress |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | ADC_W+CH_W+2 | {sof, eof, channel, amplitude} |

## Verification
The hardest case to reach is a stall that lands exactly at the end of a low phase while the ADC latency is nonzero. In that case the sample belonging to a channel has to wait out the backpressure without the multiplexer moving. The bench reaches it with one-cycle readout phases and a ready line that is high only every third cycle. The latencies of 3 and 5 put stale leading samples in front of the kept ones. The bench's chip model and pipelined ADC model are driven only by the block's own readout clock, token and reset. Any slip in channel alignment therefore shows up as a wrong amplitude or index. Extra triggers are placed during the peak wait and in the middle of the readout, and one trigger is held high across a whole event.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_CRST,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/mrs_trig_sync.sv
module mrs_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], async_i};
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/mrs_rclk_gen.sv
module mrs_rclk_gen #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          stop_i,
  input  logic          stall_i,
  input  logic [TW-1:0] hi_len_i,
  input  logic [TW-1:0] lo_len_i,
  output logic          rclk_o,
  output logic          fall_o,
  output logic          lowend_o
);
  logic          ph_q;
  logic [TW-1:0] pc_q;
  logic [TW-1:0] hi_eff, lo_eff;
  logic          hi_end, lo_done;

  assign hi_eff  = (hi_len_i == '0) ? TW'(1) : hi_len_i;
  assign lo_eff  = (lo_len_i == '0) ? TW'(1) : lo_len_i;
  assign hi_end  = ph_q & (pc_q >= hi_eff - TW'(1));
  assign lo_done = ~ph_q & (pc_q >= lo_eff - TW'(1));

  assign fall_o   = en_i & hi_end;
  assign lowend_o = en_i & lo_done & ~stall_i;
  assign rclk_o   = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 1'b0;
      pc_q <= '0;
    end else if (!en_i) begin
      ph_q <= 1'b0;
      pc_q <= '0;
    end else if (ph_q) begin
      if (hi_end) begin
        ph_q <= 1'b0;
        pc_q <= '0;
      end else begin
        pc_q <= pc_q + TW'(1);
      end
    end else if (lo_done) begin
      // low phase stretches while stalled
      if (!stall_i) begin
        ph_q <= ~stop_i;
        pc_q <= '0;
      end
    end else begin
      pc_q <= pc_q + TW'(1);
    end
  end
endmodule

// File: rtl/mrs_out_reg.sv
module mrs_out_reg #(
  parameter int W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mux_readout_seq.sv
module mux_readout_seq #(
  parameter int N_CH      = 32,
  parameter int ADC_W     = 12,
  parameter int CNT_W     = 16,
  parameter int TW        = 8,
  parameter int LAT_W     = 4,
  parameter int PEAK_DFLT = 200,
  parameter int RST_CYC   = 4,
  parameter int SYNC_STG  = 2,
  localparam int CH_W     = $clog2(N_CH),
  localparam int OUT_W    = ADC_W + CH_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] peak_dly_i,
  input  logic [TW-1:0]    rclk_hi_i,
  input  logic [TW-1:0]    rclk_lo_i,
  input  logic [LAT_W-1:0] adc_lat_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             out_ready_i,
  output logic             hold_o,
  output logic             token_o,
  output logic             rclk_o,
  output logic             chip_rst_o,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  import mrs_pkg::*;

  localparam int NPER_W = $clog2(N_CH + (2 ** LAT_W)) + 1;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [NPER_W-1:0] nf_q;
  logic              hold_q, tok_q;

  logic              trig_rise;
  logic              fall, lowend, stall, last, push;
  logic [CNT_W-1:0]  peak_eff;
  logic [NPER_W-1:0] lat_ext, nper;
  logic [CH_W-1:0]   ch_idx;
  logic [OUT_W-1:0]  word;

  mrs_trig_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (trig_i),
    .rise_o  (trig_rise)
  );

  assign stall = out_valid_o & ~out_ready_i;

  mrs_rclk_gen #(.TW(TW)) u_rclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_RUN),
    .stop_i   (last),
    .stall_i  (stall),
    .hi_len_i (rclk_hi_i),
    .lo_len_i (rclk_lo_i),
    .rclk_o   (rclk_o),
    .fall_o   (fall),
    .lowend_o (lowend)
  );

  assign peak_eff = (peak_dly_i == '0) ? CNT_W'(PEAK_DFLT) : peak_dly_i;
  assign lat_ext  = NPER_W'(adc_lat_i);
  assign nper     = NPER_W'(N_CH) + lat_ext;
  assign last     = (nf_q == nper);
  // first lat samples after the token are pipeline leftovers
  assign push     = lowend & (nf_q > lat_ext);
  assign ch_idx   = CH_W'(nf_q - NPER_W'(1) - lat_ext);
  assign word     = {ch_idx == '0, ch_idx == CH_W'(N_CH - 1), ch_idx, adc_data_i};

  mrs_out_reg #(.W(OUT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (word),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      nf_q    <= '0;
      hold_q  <= 1'b0;
      tok_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_rise) begin
            state_q <= ST_WAIT;
            wcnt_q  <= '0;
          end
        end
        ST_WAIT: begin
          if (wcnt_q == peak_eff - CNT_W'(1)) begin
            state_q <= ST_RUN;
            hold_q  <= 1'b1;
            tok_q   <= 1'b1;
            nf_q    <= '0;
          end else begin
            wcnt_q <= wcnt_q + CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (fall) begin
            nf_q  <= nf_q + NPER_W'(1);
            tok_q <= 1'b0;
          end
          if (lowend && last) begin
            state_q <= ST_CRST;
            hold_q  <= 1'b0;
            wcnt_q  <= '0;
          end
        end
        ST_CRST: begin
          if (wcnt_q == CNT_W'(RST_CYC - 1)) state_q <= ST_DRAIN;
          else                               wcnt_q  <= wcnt_q + CNT_W'(1);
        end
        ST_DRAIN: begin
          if (!out_valid_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_o     = hold_q;
  assign token_o    = tok_q;
  assign chip_rst_o = (state_q == ST_CRST);
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/mux_readout_seq_chk.sv
module mux_readout_seq_chk #(
  parameter int OUT_W = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_o,
  input logic             token_o,
  input logic             rclk_o,
  input logic             chip_rst_o,
  input logic             busy_o,
  input logic             out_ready_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_data_o
);
  AST_TOKEN_UNDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> hold_o); // R3
  AST_RCLK_UNDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rclk_o |-> hold_o); // R3
  AST_HOLD_IN_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> busy_o); // R2
  AST_RST_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> !hold_o && busy_o); // R9
  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R7
  AST_RCLK_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !rclk_o |=> !rclk_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o && !rclk_o && !hold_o); // R1
  AST_FLAGS_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_data_o[OUT_W-1] && out_data_o[OUT_W-2])); // R6
endmodule

bind mux_readout_seq mux_readout_seq_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/mux_readout_seq_bench.sv
module mux_readout_seq_bench;
  localparam int CLK_PER = 10;
  localparam int N       = 32;
  localparam int RSTC    = 4;
  localparam int PDFLT   = 200;

  typedef struct packed {
    logic [15:0] peak;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [3:0]  lat;
    logic        bp;
    logic        extra;
    logic [11:0] seed;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{16'd20, 8'd2, 8'd2, 4'd0, 1'b0, 1'b0, 12'd1},
    '{16'd7,  8'd1, 8'd1, 4'd3, 1'b1, 1'b1, 12'd2},
    '{16'd0,  8'd3, 8'd2, 4'd2, 1'b0, 1'b1, 12'd3},
    '{16'd1,  8'd1, 8'd3, 4'd5, 1'b1, 1'b0, 12'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] peak_cfg = '0;
  logic [7:0]  hi_cfg = 8'd1, lo_cfg = 8'd1;
  logic [3:0]  lat_cfg = '0;
  logic [11:0] adc_data;
  logic        ready = 1'b1;
  logic        hold, token, rclk, crst, busy, valid;
  logic [18:0] data;

  always #(CLK_PER/2) clk = ~clk;

  mux_readout_seq u_mux_readout_seq (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .peak_dly_i(peak_cfg),
    .rclk_hi_i(hi_cfg), .rclk_lo_i(lo_cfg), .adc_lat_i(lat_cfg),
    .adc_data_i(adc_data), .out_ready_i(ready), .hold_o(hold),
    .token_o(token), .rclk_o(rclk), .chip_rst_o(crst), .busy_o(busy),
    .out_valid_o(valid), .out_data_o(data)
  );

  // chip model: token shift register selecting one stored amplitude
  logic [11:0] amp_mem [0:N-1];
  logic [N-1:0] sr;
  logic [11:0] mux_val;
  logic [11:0] adc_q [0:15];

  always @(posedge rclk or posedge crst or negedge rst_n) begin
    if (!rst_n || crst) sr <= '0;
    else                sr <= {sr[N-2:0], token};
  end

  always_comb begin
    mux_val = '0;
    for (int i = N - 1; i >= 0; i--) if (sr[i]) mux_val = amp_mem[i];
  end

  always @(negedge rclk) begin
    adc_q[0] <= mux_val;
    for (int i = 1; i < 16; i++) adc_q[i] <= adc_q[i-1];
  end
  assign adc_data = adc_q[lat_cfg];

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor state
  bit          bp_mode = 1'b0;
  int          cyc = 0;
  logic [18:0] words [0:63];
  int nw, pre_hold, hold_rises, rises, hirun, lowrun, bad_hi, bad_lo;
  int bad_tok, bad_hold, bad_bp, rstrun, bad_rsthold;
  bit hold_seen, prev_hold, prev_rclk, prev_stall;
  logic [18:0] prev_data;

  task automatic clear_stats();
    nw = 0; pre_hold = 0; hold_rises = 0; rises = 0; hirun = 0; lowrun = 0;
    bad_hi = 0; bad_lo = 0; bad_tok = 0; bad_hold = 0; bad_bp = 0;
    rstrun = 0; bad_rsthold = 0; hold_seen = 0;
  endtask

  initial begin
    clear_stats();
    prev_hold = 0; prev_rclk = 0; prev_stall = 0; prev_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      ready = !bp_mode || (cyc % 3 == 0);
      if (prev_stall && !(valid && data == prev_data)) bad_bp++;
      prev_stall = valid && !ready;
      prev_data  = data;
      if (valid && ready && nw < 64) begin words[nw] = data; nw++; end
      if (busy && !hold && !hold_seen) pre_hold++;
      if (hold && !prev_hold) hold_rises++;
      if (hold) hold_seen = 1;
      prev_hold = hold;
      if (rclk) begin
        if (!prev_rclk) begin
          rises++;
          if (!hold) bad_hold++;
          if (token != (rises == 1)) bad_tok++;
          if (lowrun < int'(lo_cfg)) bad_lo++;
          lowrun = 0;
        end
        hirun++;
      end else begin
        if (prev_rclk) begin
          if (hirun != int'(hi_cfg)) bad_hi++;
          hirun = 0;
        end
        lowrun++;
      end
      prev_rclk = rclk;
      if (crst) begin
        rstrun++;
        if (hold) bad_rsthold++;
      end
    end
  end

  function automatic logic [11:0] amp_of(int c, int seed);
    return 12'((c * 181 + seed * 733 + 5) & 12'hFFF);
  endfunction

  task automatic pulse_trig(int n);
    @(negedge clk) trig = 1'b1;
    repeat (n) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic check_event(int peak, int lat);
    int exp_pk = (peak == 0) ? PDFLT : peak;
    int ch_bad = 0, fl_bad = 0;
    chk("R8 word count", nw == N, nw, N);
    chk("R8 single hold", hold_rises == 1, hold_rises, 1);
    chk("R2 busy-to-hold cycles", pre_hold == exp_pk, pre_hold, exp_pk);
    chk("R4 rising edges", rises == N + lat, rises, N + lat);
    chk("R4 high width", bad_hi == 0, bad_hi, 0);
    chk("R4 low width", bad_lo == 0, bad_lo, 0);
    chk("R3 token timing", bad_tok == 0, bad_tok, 0);
    chk("R3 hold at rclk rise", bad_hold == 0, bad_hold, 0);
    for (int i = 0; i < N && i < nw; i++) begin
      if (words[i][16:12] != 5'(i) || words[i][11:0] != amp_mem[i]) begin
        if (ch_bad == 0)
          $display("FAIL R5 word %0d act=%0h exp=%0h", i, words[i][16:0], {5'(i), amp_mem[i]});
        ch_bad++;
      end
      if (words[i][18] != (i == 0) || words[i][17] != (i == N - 1)) fl_bad++;
    end
    total++;
    if (ch_bad != 0) bad++;
    chk("R6 sof/eof flags", fl_bad == 0, fl_bad, 0);
    chk("R7 stalled word stable", bad_bp == 0, bad_bp, 0);
    chk("R9 chip reset length", rstrun == RSTC, rstrun, RSTC);
    chk("R9 hold low in chip reset", bad_rsthold == 0, bad_rsthold, 0);
    chk("R1 busy low after event", busy == 1'b0, busy, 0);
  endtask

  task automatic run_event(vec_t v);
    peak_cfg = v.peak; hi_cfg = v.hi; lo_cfg = v.lo; lat_cfg = v.lat; bp_mode = v.bp;
    for (int c = 0; c < N; c++) amp_mem[c] = amp_of(c, int'(v.seed));
    clear_stats();
    pulse_trig(3);
    if (v.extra) begin
      repeat (2) @(negedge clk);
      pulse_trig(3);                       // R8: lands in peak wait or early readout
      while (rises < 3) @(negedge clk);
      pulse_trig(4);                       // R8: lands mid readout
    end
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check_event(int'(v.peak), int'(v.lat));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 hold in reset", hold == 0, hold, 0);
    chk("R10 token in reset", token == 0, token, 0);
    chk("R10 rclk in reset", rclk == 0, rclk, 0);
    chk("R10 chip reset in reset", crst == 0, crst, 0);
    chk("R10 busy in reset", busy == 0, busy, 0);
    chk("R10 valid in reset", valid == 0, valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VECS[k]) run_event(VECS[k]);

    // R1/R8: trigger held high across a whole event starts only one
    peak_cfg = 16'd5; hi_cfg = 8'd2; lo_cfg = 8'd1; lat_cfg = 4'd1; bp_mode = 1'b0;
    for (int c = 0; c < N; c++) amp_mem[c] = amp_of(c, 9);
    clear_stats();
    @(negedge clk) trig = 1'b1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R1 held trigger one event", hold_rises == 1 && nw == N, hold_rises * 100 + nw, 100 + N);
    chk("R1 no restart while held", busy == 0, busy, 0);
    trig = 1'b0;
    repeat (5) @(negedge clk);

    // R10: reset in the middle of a readout
    clear_stats();
    pulse_trig(3);
    while (rises < 5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-event outputs low", {hold, token, rclk, crst, busy, valid} == '0,
        {hold, token, rclk, crst, busy, valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_event(VECS[0]);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule